// File: doc/BRIEF.md
# Snapshot-Read Profiling Counter

This block is a free-running event-time counter that software uses to profile code. Its width is a parameter (64 bits by default). It is reached through two read-only word slots on a simple memory-mapped bus with an address, a write strobe, a read strobe and data lines. After power-on reset the count sits at zero and idle. The first write to the low-word slot sets it running, whatever data the write carries. From then on it advances by one every fourth system clock. No bus access can stop, clear or preload it; only reset does.

Software cannot read a value this wide in one access, so reading the low-word slot also copies the whole live count into a shadow register. A later read of the high-word slot returns the upper half of that shadow rather than the live value. The pair of values is therefore coherent even when the low half carries into the high half between the two accesses. Software must read the low word first and the high word second.

Read data comes back registered, one clock after the read strobe, with a one-cycle valid flag. The block has no ready input and cannot be back-pressured. The bus master must accept each returned word in the cycle its valid flag is high.

Top module: `prof_counter64`

## Requirements
- R1: While reset is low and after it is released, `rd_data` and `rd_valid` are zero, the count is idle at zero, and the shadow register reads back as zero.
- R2: A read strobe on a clock edge makes `rd_valid` high for exactly the following cycle, with `rd_data` valid in that cycle; without a read strobe `rd_valid` is low.
- R3: The count stays at zero until a write to the low-word address (offset 0x0). That write only starts the counter and its data is ignored; a write to the high-word address (offset 0x4) does not start it.
- R4: Once started, no write to any address with any data clears, stops or restarts the count; only reset returns it to idle at zero.
- R5: The count advances by exactly one every four clock edges. The first increment lands on the fourth edge after the edge that captured the starting write.
- R6: A read of offset 0x0 returns the low half of the count as it stood before that edge and, on the same edge, captures the full count into the shadow register; an increment on that same edge is not included.
- R7: A read of offset 0x4 returns the upper half of the shadow register captured by the most recent low-word read, not the live count; the shadow changes only on a low-word read.
- R8: After the all-ones value the count wraps to zero and keeps counting at the same rate.
- R9: A read of any address other than 0x0 and 0x4 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | CNT_W/2 | Write data, ignored by the block |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| rd_data | output | CNT_W/2 | Registered read data |
| rd_valid | output | 1 | High for the one cycle in which `rd_data` answers a read |

## Verification
The assertions assume the bus issues single-cycle strobes and that each returned word is taken in its valid cycle, since nothing can stall the block. They also assume a low-word read is the only event that may rewrite the shadow. The bench drives every strobe for exactly one clock, from the falling edge, and never drives a read and a write together. It keeps an idle cycle after each access, so every response lines up with exactly one queued expectation. The bench builds the block with a 12-bit count. With that width, the carry between halves and the full wrap both occur within the run time, while the logic is the same as at the default width.

// File: rtl/prof_cnt_pkg.sv
package prof_cnt_pkg;

  // Which slot a read strobe selects this cycle.
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } rd_sel_e;

endpackage

// File: rtl/prof_cnt_pace.sv
// Start latch and divide-by-DIV prescaler.
module prof_cnt_pace #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic running,
  output logic tick
);
  localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      phase   <= '0;
    end else begin
      if (start_req) running <= 1'b1;
      if (running) phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  assign tick = running && (phase == LAST);

endmodule

// File: rtl/prof_cnt_acc.sv
// Wrapping accumulator stepped by the prescaler tick.
module prof_cnt_acc #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= count + 1'b1;
  end
endmodule

// File: rtl/prof_cnt_snap.sv
// Shadow capture and registered read mux.
module prof_cnt_snap
  import prof_cnt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_go,
  input  rd_sel_e           sel,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  snap,
  output logic [CNT_W/2-1:0] rd_data,
  output logic              rd_valid
);
  localparam int HALF_W = CNT_W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap     <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (rd_go) begin
        unique case (sel)
          SEL_LO: begin
            snap    <= count;
            rd_data <= count[HALF_W-1:0];
          end
          SEL_HI:  rd_data <= snap[CNT_W-1:HALF_W];
          default: rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/prof_counter64.sv
module prof_counter64
  import prof_cnt_pkg::*;
#(
  parameter int                CNT_W   = 64,
  parameter int                DIV     = 4,
  parameter int                ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [CNT_W/2-1:0]   bus_wdata,
  input  logic                 bus_rd,
  output logic [CNT_W/2-1:0]   rd_data,
  output logic                 rd_valid
);
  logic             running;
  logic             tick;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] snap;
  logic             lo_hit;
  logic             hi_hit;
  logic             start_req;
  rd_sel_e          sel;

  // Write data carries no meaning; keep it visibly consumed.
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  assign lo_hit    = (bus_addr == LO_ADDR);
  assign hi_hit    = (bus_addr == HI_ADDR);
  assign start_req = bus_wr && lo_hit;

  always_comb begin
    if (lo_hit)      sel = SEL_LO;
    else if (hi_hit) sel = SEL_HI;
    else             sel = SEL_NONE;
  end

  prof_cnt_pace #(.DIV(DIV)) u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .running   (running),
    .tick      (tick)
  );

  prof_cnt_acc #(.CNT_W(CNT_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .count (count)
  );

  prof_cnt_snap #(.CNT_W(CNT_W)) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_go    (bus_rd),
    .sel      (sel),
    .count    (count),
    .snap     (snap),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/prof_cnt_chk.sv
module prof_cnt_chk #(
  parameter int                CNT_W   = 64,
  parameter int                DIV     = 4,
  parameter int                ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] LO_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] HI_ADDR = 'h4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_rd,
  input logic [CNT_W/2-1:0]  rd_data,
  input logic                rd_valid,
  input logic                running,
  input logic [CNT_W-1:0]    count,
  input logic [CNT_W-1:0]    snap
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic lo_rd, hi_rd;
  assign lo_rd = bus_rd && (bus_addr == LO_ADDR);
  assign hi_rd = bus_rd && (bus_addr == HI_ADDR);

  // Spacing monitor: cycles the count has held still.
  logic [CNT_W-1:0] prev_count;
  int unsigned      still_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_count <= '0;
      still_cnt  <= DIV;
    end else begin
      prev_count <= count;
      if (count != prev_count) still_cnt <= 0;
      else if (still_cnt < DIV) still_cnt <= still_cnt + 1;
    end
  end

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (count == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);

  a_r2_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid);

  a_r4_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (count == $past(count) || count == $past(count) + ONE));

  a_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (count != prev_count) |-> (still_cnt >= DIV - 1));

  a_r6_lo_data: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> (rd_data == $past(count[HALF_W-1:0])));

  a_r6_snap_take: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> (snap == $past(count)));

  a_r7_hi_data: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> (rd_data == $past(snap[CNT_W-1:HALF_W])));

  a_r7_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_rd |=> $stable(snap));

  a_r9_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !lo_rd && !hi_rd) |=> (rd_data == '0));

endmodule

bind prof_counter64 prof_cnt_chk #(
  .CNT_W(CNT_W), .DIV(DIV), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .rd_data  (rd_data),
  .rd_valid (rd_valid),
  .running  (running),
  .count    (count),
  .snap     (snap)
);

// File: tb/test_prof_counter64.sv
module test_prof_counter64;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 12;
  localparam int H      = CNT_W / 2;
  localparam int DIV    = 4;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_LO  = 4'h0;
  localparam logic [ADDR_W-1:0] A_HI  = 4'h4;
  localparam logic [ADDR_W-1:0] A_OTH = 4'h8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [H-1:0]      bus_wdata = '0;
  logic              bus_rd = 1'b0;
  logic [H-1:0]      rd_data;
  logic              rd_valid;

  int     errs = 0;
  int     checks = 0;
  longint cyc = 0;
  longint start_cyc = -1;
  logic [CNT_W-1:0] exp_snap = '0;
  logic [H-1:0] exp_q[$];
  string        tag_q[$];
  bit           done = 0;

  prof_counter64 #(.CNT_W(CNT_W), .DIV(DIV), .ADDR_W(ADDR_W),
                   .LO_ADDR(A_LO), .HI_ADDR(A_HI)) i_prof_counter64 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Count expected after 'c' edges, from the requirements (R3, R5, R8).
  function automatic logic [CNT_W-1:0] model(longint c);
    if (start_cyc < 0 || c < start_cyc) return '0;
    return CNT_W'((c - start_cyc) / DIV);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check(0, "R2 unexpected rd_valid", 1, 0);
      else begin
        logic [H-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, rd_data, e);
      end
    end
  end

  // Driver tasks: called at a falling edge, return at a falling edge.
  task automatic do_read(logic [ADDR_W-1:0] a, string tag);
    logic [CNT_W-1:0] now;
    now = model(cyc);
    if (a == A_LO) begin
      exp_snap = now;
      exp_q.push_back(now[H-1:0]);
    end else if (a == A_HI) exp_q.push_back(exp_snap[CNT_W-1:H]);
    else exp_q.push_back('0);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [H-1:0] d);
    if (a == A_LO && start_cyc < 0) start_cyc = cyc + 1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    check(rd_valid == 1'b0, "R1 rd_valid in reset", rd_valid, 0);
    check(rd_data == '0, "R1 rd_data in reset", rd_data, 0);
    start_cyc = -1;
    exp_snap = '0;
    rst_n = 1'b1;
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: shadow and count read back zero
    do_read(A_HI, "R1 shadow high after reset");
    do_read(A_LO, "R1 count low after reset");
    // R3: high-slot write does not start; idle stays zero
    do_write(A_HI, 6'h3F);
    idle(12);
    do_read(A_LO, "R3 idle after high write");
    do_read(A_HI, "R3 idle high");
    // R3: start with nonzero data, data ignored
    do_write(A_LO, 6'h2A);
    // R5/R6: reads at every prescaler phase
    for (int i = 0; i < 14; i++) begin
      idle(i % 5);
      do_read(A_LO, "R5 R6 low read at varied phase");
      do_read(A_HI, "R6 paired high read");
    end
    // R9
    do_read(A_OTH, "R9 other address");
    // R4: writes of arbitrary data while running
    do_write(A_LO, 6'h00);
    do_write(A_LO, 6'h3F);
    do_write(A_HI, 6'h15);
    do_write(A_OTH, 6'h2A);
    do_read(A_LO, "R4 low after running writes");
    do_read(A_HI, "R4 high after running writes");
    // R7: low reads all-ones, carry happens before high read
    while (model(cyc)[H-1:0] != {H{1'b1}} || model(cyc + 2)[H-1:0] != {H{1'b1}}) idle(1);
    do_read(A_LO, "R7 low before carry");
    idle(8);
    do_read(A_HI, "R7 high from shadow, not live");
    check(model(cyc)[CNT_W-1:H] != exp_snap[CNT_W-1:H], "R7 live high advanced",
          model(cyc)[CNT_W-1:H], exp_snap[CNT_W-1:H] + 1);
    do_read(A_LO, "R7 low after carry");
    do_read(A_HI, "R7 high after carry");
    // R8: wrap at all ones
    while (model(cyc) != {CNT_W{1'b1}}) idle(1);
    do_read(A_LO, "R8 low at all ones");
    do_read(A_HI, "R8 high at all ones");
    idle(6);
    do_read(A_LO, "R8 low after wrap");
    do_read(A_HI, "R8 high after wrap");
    idle(9);
    do_read(A_LO, "R8 counting continues after wrap");
    // R4: reset is the only way back to idle
    do_reset();
    idle(10);
    do_read(A_LO, "R4 idle after reset");
    do_read(A_HI, "R4 shadow cleared by reset");
    do_write(A_LO, 6'h11);
    idle(9);
    do_read(A_LO, "R5 restart after reset");
    idle(3);
    check(exp_q.size() == 0, "R2 missing responses", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule